// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Controller

The block watches the output of a demodulated infrared receiver and turns one remote-control message into a list of durations. The receiver pin is active-low and is synchronized internally. On every sample tick the controller looks at the line. Each mark (line low) and each space (line high) is measured as an 8-bit number of sample periods. The widths are packed four to a 32-bit word into a bank of seventeen capture words, which holds 68 widths in all.

A message ends when a space has lasted 255 sample periods. Capture also stops when all 68 slots are full. Either way the interrupt status is set and the bank is frozen, so software can read it without racing new input. Software then issues a restart, which empties the bank and rearms the controller, and acknowledges the interrupt.

All access is through a plain register port. A write takes effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. The port has no handshake and cannot stall.

Top module: `ir_pulse_capture`

## Requirements
- R1: The sample tick occurs once every 4*N clock cycles. N is the 13-bit field at bits 20:8 of the tick register (offset 0x04). An N of 0 acts as 1.
- R2: Ticks and capture run only while both bit 0 and bit 13 of the control register (offset 0x00) are 1. With either bit clear, input activity leaves the bank and the status unchanged.
- R3: The receiver input is active-low and passes through two synchronizing flops. While idle, a message begins on the first tick that samples the line active after a tick that sampled it inactive. The first width of a message is always a mark.
- R4: Each width is the number of ticks on which its level was sampled. Widths alternate mark, space, mark, and so on. A mark longer than 255 ticks is stored as 255.
- R5: Slot k goes to bits 8*(k mod 4)+7 down to 8*(k mod 4) of bank word k/4. Bank word w is read at offset 0x40+4*w, for w from 0 to 16.
- R6: When a space reaches 255 ticks, the value 255 is stored and capture stops without waiting for another edge. The interrupt status is then set.
- R7: When the 68th slot is written, capture stops and the interrupt status is set, even though no terminating space was seen.
- R8: After capture stops, input activity changes neither the bank nor the status until a restart.
- R9: Writing 1 to bit 0 at offset 0x08 zeroes every bank word and returns to idle. The next message starts at slot 0.
- R10: The output `irq` is the interrupt status ANDed with bit 0 of the enable register (offset 0x0C). The status can be read at bit 0 of offset 0x14.
- R11: Writing 1 to bit 0 at offset 0x10 clears the interrupt status.
- R12: After reset the following hold: the bank reads zero, the status is clear, `irq` is low, and the control and enable registers read zero. The tick register reads N = 3072.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_rx_n | input | 1 | Raw receiver output, low during a mark |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Capture-complete interrupt |

## Verification
The first test is a message of unequal marks and spaces ended by a long space. It shows whether widths land in the right byte lanes, alternate starting with a mark, and whether capture ends on the saturated space. A train of 35 equal mark/space pairs fills all 68 slots and separates the full-bank stop from the end-of-message stop. A 300-tick mark separates mark saturation from end detection. The same message is also driven in clock units after the tick field changes, which exposes a wrong divider or a misplaced field. Activity after a stop, with either enable bit cleared, and with the interrupt masked, checks that frozen or gated state really stays unchanged.

// File: rtl/ircap_pkg.sv
package ircap_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} cap_state_e;

  localparam logic [7:0] ADDR_CTRL     = 8'h00;
  localparam logic [7:0] ADDR_TICK     = 8'h04;
  localparam logic [7:0] ADDR_RESTART  = 8'h08;
  localparam logic [7:0] ADDR_IRQ_EN   = 8'h0C;
  localparam logic [7:0] ADDR_IRQ_ACK  = 8'h10;
  localparam logic [7:0] ADDR_IRQ_STAT = 8'h14;
  localparam logic [7:0] ADDR_BANK     = 8'h40;

  localparam int CTRL_RX_BIT  = 0;
  localparam int CTRL_PW_BIT  = 13;
  localparam int TICK_LSB     = 8;
endpackage

// File: rtl/ircap_tick.sv
module ircap_tick #(
  parameter int DIV = 4,
  parameter int PW  = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] period,
  output logic          tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;
  logic [PW-1:0] cnt_q;
  logic          div_hit, per_hit;

  assign div_hit = (div_q == DW'(DIV - 1));
  assign per_hit = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (!en) begin
      div_q <= '0;
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= div_hit && per_hit;
      if (div_hit) begin
        div_q <= '0;
        cnt_q <= per_hit ? '0 : cnt_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R2: no tick once the enables are dropped
  assert_tick_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick);
endmodule

// File: rtl/ircap_sync.sv
module ircap_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_n,
  output logic active
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rx_n;
      s2_q <= s1_q;
    end
  end

  assign active = ~s2_q;
endmodule

// File: rtl/ircap_engine.sv
module ircap_engine
  import ircap_pkg::*;
#(
  parameter int WORDS = 17,
  parameter int WW    = 8,
  parameter int PER   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       active,
  input  logic                       restart,
  output logic [WORDS-1:0][WW*PER-1:0] bank,
  output logic                       done_pulse
);
  localparam int SLOTS = WORDS * PER;
  localparam int IW    = $clog2(SLOTS + 1);
  localparam logic [WW-1:0] MAXW = {WW{1'b1}};

  cap_state_e      state_q;
  logic [IW-1:0]   idx_q;
  logic [WW-1:0]   cnt_q;
  logic            cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      cnt_q      <= '0;
      cur_q      <= 1'b0;
      prev_q     <= 1'b0;
      bank       <= '0;
      done_pulse <= 1'b0;
    end else if (restart) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      cnt_q      <= '0;
      cur_q      <= 1'b0;
      bank       <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (tick) begin
        prev_q <= active;
        unique case (state_q)
          ST_IDLE: if (active && !prev_q) begin
            state_q <= ST_RUN;
            cur_q   <= 1'b1;
            cnt_q   <= WW'(1);
          end
          ST_RUN: if (active == cur_q) begin
            if (cnt_q != MAXW) cnt_q <= cnt_q + 1'b1;
            if (!cur_q && cnt_q == MAXW - 1'b1) begin
              for (int w = 0; w < WORDS; w++)
                for (int s = 0; s < PER; s++)
                  if (idx_q == IW'(w * PER + s)) bank[w][s*WW +: WW] <= MAXW;
              state_q    <= ST_DONE;
              done_pulse <= 1'b1;
            end
          end else begin
            for (int w = 0; w < WORDS; w++)
              for (int s = 0; s < PER; s++)
                if (idx_q == IW'(w * PER + s)) bank[w][s*WW +: WW] <= cnt_q;
            idx_q <= idx_q + 1'b1;
            cur_q <= active;
            cnt_q <= WW'(1);
            if (idx_q == IW'(SLOTS - 1)) begin
              state_q    <= ST_DONE;
              done_pulse <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7: slot index never runs past the bank
  assert_slot_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(SLOTS));
  // R8: a stopped capture keeps its bank
  assert_bank_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && !restart) |=> $stable(bank));
  // R9: restart empties the bank and rearms
  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (bank == '0 && state_q == ST_IDLE && idx_q == '0));
  // R3: a message opens with a mark at slot 0
  assert_mark_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && $past(state_q) == ST_IDLE) |-> (cur_q && idx_q == '0));
endmodule

// File: rtl/ir_pulse_capture.sv
module ir_pulse_capture
  import ircap_pkg::*;
#(
  parameter int WORDS      = 17,
  parameter int WW         = 8,
  parameter int DIV        = 4,
  parameter int PW         = 13,
  parameter int PERIOD_RST = 3072
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_rx_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int PER = 32 / WW;

  logic          rx_en_q, pw_en_q, irq_en_q, stat_q;
  logic [PW-1:0] period_q;
  logic          tick, active, done_pulse, restart, ack;
  logic [WORDS-1:0][31:0] bank;

  assign restart = reg_wr && reg_addr == ADDR_RESTART && reg_wdata[0];
  assign ack     = reg_wr && reg_addr == ADDR_IRQ_ACK && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q  <= 1'b0;
      pw_en_q  <= 1'b0;
      irq_en_q <= 1'b0;
      period_q <= PW'(PERIOD_RST);
      stat_q   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL) begin
        rx_en_q <= reg_wdata[CTRL_RX_BIT];
        pw_en_q <= reg_wdata[CTRL_PW_BIT];
      end
      if (reg_wr && reg_addr == ADDR_TICK) period_q <= reg_wdata[TICK_LSB +: PW];
      if (reg_wr && reg_addr == ADDR_IRQ_EN) irq_en_q <= reg_wdata[0];
      if (done_pulse) stat_q <= 1'b1;
      else if (ack)   stat_q <= 1'b0;
    end
  end

  assign irq = stat_q & irq_en_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTRL_RX_BIT] = rx_en_q;
        reg_rdata[CTRL_PW_BIT] = pw_en_q;
      end
      ADDR_TICK:     reg_rdata[TICK_LSB +: PW] = period_q;
      ADDR_IRQ_EN:   reg_rdata[0] = irq_en_q;
      ADDR_IRQ_STAT: reg_rdata[0] = stat_q;
      default: begin
        for (int w = 0; w < WORDS; w++)
          if (reg_addr == 8'(ADDR_BANK + 4 * w)) reg_rdata = bank[w];
      end
    endcase
  end

  ircap_tick #(.DIV(DIV), .PW(PW)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(rx_en_q && pw_en_q),
    .period(period_q), .tick(tick));

  ircap_sync u_sync (.clk(clk), .rst_n(rst_n), .rx_n(ir_rx_n), .active(active));

  ircap_engine #(.WORDS(WORDS), .WW(WW), .PER(PER)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(active),
    .restart(restart), .bank(bank), .done_pulse(done_pulse));

  // R6: a finished capture raises the status
  assert_done_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> stat_q);
  // R11: acknowledge clears the status when no new completion collides
  assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !done_pulse) |=> !stat_q);
endmodule

// File: tb/sim_ir_pulse_capture.sv
`timescale 1ns/1ps
module sim_ir_pulse_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_rx_n = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int tclk = 8;
  bit finished = 0;

  always #5 clk = ~clk;

  ir_pulse_capture u0 (
    .clk(clk), .rst_n(rst_n), .ir_rx_n(ir_rx_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic hold(input logic lvl, input int ticks);
    @(negedge clk);
    ir_rx_n = lvl;
    repeat (ticks * tclk - 1) @(negedge clk);
  endtask

  task automatic rearm();
    wr(8'h10, 32'h1);
    wr(8'h08, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R12 ctrl", d, 32'h0);
    rd(8'h04, d); chk("R12 tick", d, 32'd3072 << 8);
    rd(8'h40, d); chk("R12 word0", d, 32'h0);
    rd(8'h80, d); chk("R12 word16", d, 32'h0);
    rd(8'h14, d); chk("R12 stat", d, 32'h0);
    chk("R12 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    hold(1, 3);
    hold(0, 9); hold(1, 4); hold(0, 2); hold(1, 3); hold(0, 5);
    hold(1, 260);
    rd(8'h40, d); chk("R5 R3 word0", d, 32'h03020409);
    rd(8'h44, d); chk("R6 word1", d, 32'h0000FF05);
    rd(8'h48, d); chk("R4 word2", d, 32'h0);
    chk("R6 irq", {31'b0, irq}, 32'h1);
    // R8: activity after the stop is ignored
    hold(0, 10); hold(1, 10);
    rd(8'h40, d); chk("R8 word0", d, 32'h03020409);
    rd(8'h44, d); chk("R8 word1", d, 32'h0000FF05);
    wr(8'h10, 32'h1);
    rd(8'h14, d); chk("R11 stat", d, 32'h0);
    chk("R11 irq", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h1);
    rd(8'h40, d); chk("R9 word0", d, 32'h0);
    rd(8'h44, d); chk("R9 word1", d, 32'h0);
  endtask

  task automatic t_full();
    logic [31:0] d;
    hold(1, 2);
    for (int i = 0; i < 35; i++) begin
      hold(0, 2);
      if (i < 34) hold(1, 2);
    end
    hold(1, 20);
    rd(8'h40, d); chk("R7 word0", d, 32'h02020202);
    rd(8'h80, d); chk("R7 word16", d, 32'h02020202);
    chk("R7 irq", {31'b0, irq}, 32'h1);
    rearm();
  endtask

  task automatic t_sat();
    logic [31:0] d;
    hold(1, 2); hold(0, 300); hold(1, 260);
    rd(8'h40, d); chk("R4 saturated mark", d, 32'h0000FFFF);
    rearm();
  endtask

  task automatic t_irq_mask();
    logic [31:0] d;
    wr(8'h0C, 32'h0);
    hold(1, 2); hold(0, 3); hold(1, 260);
    chk("R10 masked irq", {31'b0, irq}, 32'h0);
    rd(8'h14, d); chk("R10 stat", d, 32'h1);
    wr(8'h0C, 32'h1);
    chk("R10 unmasked irq", {31'b0, irq}, 32'h1);
    rearm();
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(8'h00, 32'h1);
    hold(1, 2); hold(0, 4); hold(1, 3); hold(0, 4); hold(1, 300);
    rd(8'h40, d); chk("R2 word0", d, 32'h0);
    rd(8'h14, d); chk("R2 stat", d, 32'h0);
    wr(8'h00, 32'h2001);
  endtask

  task automatic t_period();
    logic [31:0] d;
    wr(8'h04, 32'd4 << 8);
    tclk = 16;
    hold(1, 2);
    hold(0, 3); hold(1, 2); hold(0, 1); hold(1, 260);
    rd(8'h40, d); chk("R1 period 4", d, 32'hFF010203);
    chk("R1 irq", {31'b0, irq}, 32'h1);
    rearm();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    wr(8'h04, 32'd2 << 8);
    wr(8'h0C, 32'h1);
    wr(8'h00, 32'h2001);
    t_basic();
    t_full();
    t_sat();
    t_irq_mask();
    t_enable();
    t_period();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule